// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the word address sequence for a multi-register load or store. A start strobe captures a base address, a 16-bit register mask and an addressing mode. The block then hands one (register index, word address) pair per cycle to the memory side over a valid/ready handshake. When the last pair has been accepted, it pulses a done flag for one cycle and presents the updated base value. A writeback enable tells the register file whether to store that value.

The mode is either one of four direct address modes or one of four stack disciplines. A small decoder maps each stack discipline onto a direct mode, and the mapping depends on whether the operation is a load or a store. Registers always go out in ascending index order, and the lowest index always gets the lowest address. Decrementing modes therefore compute their start address from the number of selected registers.

Top module: `mtx_addr_seq`

## Requirements
- R1: Mode code 0 (increment-after): with N selected registers, the k-th transfer (k from 0) uses base+4k, and the final base is base+4N.
- R2: Mode code 1 (increment-before): the k-th transfer uses base+4+4k, and the final base is base+4N.
- R3: Mode code 2 (decrement-after): the k-th transfer uses base-4N+4+4k, and the final base is base-4N.
- R4: Mode code 3 (decrement-before): the k-th transfer uses base-4N+4k, and the final base is base-4N.
- R5: Transfers present the set bits of the mask in ascending index order, one pair per accepted handshake.
- R6: On the done pulse, wb_base_o carries the final base, and wb_en_o equals the writeback input captured at start.
- R7: With stack_sel_i=1 and load_i=0, stack kind 0 (full-descending) acts as mode 3, kind 1 (full-ascending) as mode 1, kind 2 (empty-descending) as mode 2, and kind 3 (empty-ascending) as mode 0. While stack_sel_i=1, mode_i is ignored.
- R8: With stack_sel_i=1 and load_i=1, kind 0 acts as mode 0, kind 1 as mode 2, kind 2 as mode 1, and kind 3 as mode 3.
- R9: An all-zero mask produces no transfer. done_o rises the cycle after the start edge, and wb_base_o equals the unchanged base.
- R10: done_o is high for exactly one cycle, in the cycle after the final handshake is accepted.
- R11: While req_valid_o is high and req_ready_i is low, req_valid_o, req_idx_o and req_addr_o hold their values.
- R12: A start strobe that arrives while busy_o is high is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when not busy |
| base_i | input | 32 | Base address |
| reglist_i | input | 16 | Register selection mask |
| stack_sel_i | input | 1 | 1: use stack_kind_i; 0: use mode_i |
| stack_kind_i | input | 2 | Stack discipline code |
| load_i | input | 1 | 1 for load, 0 for store |
| mode_i | input | 2 | Direct address mode code |
| wback_i | input | 1 | Writeback requested |
| req_valid_o | output | 1 | Transfer pair valid |
| req_ready_i | input | 1 | Memory side accepts pair |
| req_idx_o | output | 4 | Register index of the pair |
| req_addr_o | output | 32 | Word address of the pair |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Base writeback strobe |
| wb_base_o | output | 32 | Final base value |
| busy_o | output | 1 | Sequence in progress |

## Verification
The first pair appears in the cycle after the start edge. Each following pair appears in the cycle after the previous pair is accepted. done_o and the writeback outputs are due one cycle after the last acceptance, or one cycle after the start edge for an empty mask. The driver pushes every expected pair into a queue. The monitor samples at the falling edge, pops and compares a pair on each accepted handshake, and derives the cycle in which done is due from the handshakes it has seen. Random ready patterns exercise the hold behaviour while pairs are stalled.

// File: rtl/mtx_seq_pkg.sv
package mtx_seq_pkg;

    typedef enum logic [1:0] {
        AM_INC_AFTER  = 2'd0,
        AM_INC_BEFORE = 2'd1,
        AM_DEC_AFTER  = 2'd2,
        AM_DEC_BEFORE = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        SK_FULL_DESC  = 2'd0,
        SK_FULL_ASC   = 2'd1,
        SK_EMPTY_DESC = 2'd2,
        SK_EMPTY_ASC  = 2'd3
    } stack_kind_e;

endpackage

// File: rtl/mtx_stack_map.sv
module mtx_stack_map
    import mtx_seq_pkg::*;
(
    input  logic        stack_sel_i,
    input  logic [1:0]  stack_kind_i,
    input  logic        load_i,
    input  logic [1:0]  mode_i,
    output addr_mode_e  mode_o
);

    always_comb begin
        mode_o = addr_mode_e'(mode_i);
        if (stack_sel_i) begin
            unique case (stack_kind_e'(stack_kind_i))
                SK_FULL_DESC:  mode_o = load_i ? AM_INC_AFTER  : AM_DEC_BEFORE;
                SK_FULL_ASC:   mode_o = load_i ? AM_DEC_AFTER  : AM_INC_BEFORE;
                SK_EMPTY_DESC: mode_o = load_i ? AM_INC_BEFORE : AM_DEC_AFTER;
                SK_EMPTY_ASC:  mode_o = load_i ? AM_DEC_BEFORE : AM_INC_AFTER;
                default:       mode_o = AM_INC_AFTER;
            endcase
        end
    end

endmodule

// File: rtl/mtx_mask_scan.sv
module mtx_mask_scan #(
    parameter int NREG = 16,
    localparam int IW = $clog2(NREG),
    localparam int CW = $clog2(NREG + 1)
) (
    input  logic [NREG-1:0] mask_i,
    output logic            any_o,
    output logic [IW-1:0]   low_idx_o,
    output logic [CW-1:0]   count_o
);

    always_comb begin
        low_idx_o = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (mask_i[i]) low_idx_o = IW'(i);
        end
    end

    always_comb begin
        count_o = '0;
        for (int i = 0; i < NREG; i++) begin
            count_o = count_o + CW'(mask_i[i]);
        end
    end

    assign any_o = |mask_i;

endmodule

// File: rtl/mtx_addr_plan.sv
module mtx_addr_plan
    import mtx_seq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CW         = 5,
    parameter int WORD_BYTES = 4,
    localparam int SHIFT = $clog2(WORD_BYTES)
) (
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    input  addr_mode_e    mode_i,
    output logic [AW-1:0] first_o,
    output logic [AW-1:0] final_o
);

    logic [AW-1:0] span;
    logic [AW-1:0] word;

    assign span = AW'(count_i) << SHIFT;
    assign word = AW'(WORD_BYTES);

    always_comb begin
        unique case (mode_i)
            AM_INC_AFTER: begin
                first_o = base_i;
                final_o = base_i + span;
            end
            AM_INC_BEFORE: begin
                first_o = base_i + word;
                final_o = base_i + span;
            end
            AM_DEC_AFTER: begin
                first_o = base_i - span + word;
                final_o = base_i - span;
            end
            default: begin
                first_o = base_i - span;
                final_o = base_i - span;
            end
        endcase
    end

endmodule

// File: rtl/mtx_addr_seq.sv
module mtx_addr_seq
    import mtx_seq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IW = $clog2(NREG),
    localparam int CW = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [AW-1:0]   base_i,
    input  logic [NREG-1:0] reglist_i,
    input  logic            stack_sel_i,
    input  logic [1:0]      stack_kind_i,
    input  logic            load_i,
    input  logic [1:0]      mode_i,
    input  logic            wback_i,
    output logic            req_valid_o,
    input  logic            req_ready_i,
    output logic [IW-1:0]   req_idx_o,
    output logic [AW-1:0]   req_addr_o,
    output logic            done_o,
    output logic            wb_en_o,
    output logic [AW-1:0]   wb_base_o,
    output logic            busy_o
);

    typedef struct packed {
        logic            busy;
        logic [NREG-1:0] remain;
        logic [AW-1:0]   addr;
        logic [AW-1:0]   final_base;
        logic            wback;
        logic            done;
    } seq_state_t;

    seq_state_t st_d, st_q;

    addr_mode_e      eff_mode;
    logic            list_any;
    logic [IW-1:0]   list_low_unused;
    logic [CW-1:0]   list_count;
    logic            rem_any_unused;
    logic [IW-1:0]   rem_low;
    logic [CW-1:0]   rem_count_unused;
    logic [AW-1:0]   plan_first;
    logic [AW-1:0]   plan_final;
    logic [NREG-1:0] rem_next;
    logic            accept;

    mtx_stack_map u_map (
        .stack_sel_i  (stack_sel_i),
        .stack_kind_i (stack_kind_i),
        .load_i       (load_i),
        .mode_i       (mode_i),
        .mode_o       (eff_mode)
    );

    mtx_mask_scan #(.NREG(NREG)) u_scan_list (
        .mask_i    (reglist_i),
        .any_o     (list_any),
        .low_idx_o (list_low_unused),
        .count_o   (list_count)
    );

    mtx_mask_scan #(.NREG(NREG)) u_scan_rem (
        .mask_i    (st_q.remain),
        .any_o     (rem_any_unused),
        .low_idx_o (rem_low),
        .count_o   (rem_count_unused)
    );

    mtx_addr_plan #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_plan (
        .base_i  (base_i),
        .count_i (list_count),
        .mode_i  (eff_mode),
        .first_o (plan_first),
        .final_o (plan_final)
    );

    assign accept   = st_q.busy && req_ready_i;
    assign rem_next = st_q.remain & (st_q.remain - NREG'(1));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (accept) begin
                st_d.remain = rem_next;
                st_d.addr   = st_q.addr + AW'(WORD_BYTES);
                if (rem_next == '0) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
            end
        end else if (start_i) begin
            st_d.busy       = list_any;
            st_d.remain     = reglist_i;
            st_d.addr       = plan_first;
            st_d.final_base = plan_final;
            st_d.wback      = wback_i;
            st_d.done       = !list_any;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_valid_o = st_q.busy;
    assign req_idx_o   = rem_low;
    assign req_addr_o  = st_q.addr;
    assign done_o      = st_q.done;
    assign wb_en_o     = st_q.done && st_q.wback;
    assign wb_base_o   = st_q.final_base;
    assign busy_o      = st_q.busy;

endmodule

// File: rtl/mtx_addr_seq_chk.sv
module mtx_addr_seq_chk #(
    parameter int AW         = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IW = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [NREG-1:0] reglist_i,
    input logic            req_valid_o,
    input logic            req_ready_i,
    input logic [IW-1:0]   req_idx_o,
    input logic [AW-1:0]   req_addr_o,
    input logic            done_o,
    input logic            wb_en_o,
    input logic            busy_o
);

    // R5: after an accepted pair, any next pair has a higher index
    p_idx_rises_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i) |=> (!req_valid_o || req_idx_o > $past(req_idx_o)));

    // R1..R4: consecutive pairs are one word apart
    p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i) |=>
            (!req_valid_o || req_addr_o == $past(req_addr_o) + AW'(WORD_BYTES)));

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10, R9: done follows a final accept or an empty-list start
    p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(req_valid_o && req_ready_i) ||
                           $past(start_i && !busy_o && reglist_i == '0)));

    // R11: stalled pair is held
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=>
            (req_valid_o && $stable(req_idx_o) && $stable(req_addr_o)));

    // R6: writeback strobe only with done
    p_wb_in_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> done_o);

    // R9: no pair in flight while done
    p_no_req_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !req_valid_o);

endmodule

bind mtx_addr_seq mtx_addr_seq_chk #(.AW(AW), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .reglist_i   (reglist_i),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_idx_o   (req_idx_o),
    .req_addr_o  (req_addr_o),
    .done_o      (done_o),
    .wb_en_o     (wb_en_o),
    .busy_o      (busy_o)
);

// File: tb/test_mtx_addr_seq.sv
module test_mtx_addr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] reglist_i = '0;
    logic        stack_sel_i = 1'b0;
    logic [1:0]  stack_kind_i = '0;
    logic        load_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic        wback_i = 1'b0;
    logic        req_valid_o;
    logic        req_ready_i = 1'b1;
    logic [3:0]  req_idx_o;
    logic [31:0] req_addr_o;
    logic        done_o;
    logic        wb_en_o;
    logic [31:0] wb_base_o;
    logic        busy_o;

    int checks = 0;
    int errors = 0;

    int          exp_idx_q[$];
    logic [31:0] exp_addr_q[$];
    logic [31:0] exp_base;
    logic        exp_wben;
    string       cur_tag = "R0";
    bit          seen_done = 1'b0;
    bit          rnd_ready = 1'b0;
    logic [7:0]  lfsr = 8'hA5;

    always #5 clk = ~clk;

    mtx_addr_seq i_mtx_addr_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .base_i       (base_i),
        .reglist_i    (reglist_i),
        .stack_sel_i  (stack_sel_i),
        .stack_kind_i (stack_kind_i),
        .load_i       (load_i),
        .mode_i       (mode_i),
        .wback_i      (wback_i),
        .req_valid_o  (req_valid_o),
        .req_ready_i  (req_ready_i),
        .req_idx_o    (req_idx_o),
        .req_addr_o   (req_addr_o),
        .done_o       (done_o),
        .wb_en_o      (wb_en_o),
        .wb_base_o    (wb_base_o),
        .busy_o       (busy_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // ready driver
    initial begin
        forever begin
            @(posedge clk);
            #2;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            req_ready_i = rnd_ready ? lfsr[0] : 1'b1;
        end
    end

    // monitor / scoreboard
    bit          exp_done = 1'b0;
    bit          hold_pend = 1'b0;
    logic [3:0]  hold_idx;
    logic [31:0] hold_addr;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                bit nxt_done;
                nxt_done = 1'b0;
                if (done_o || exp_done) begin
                    chk(done_o == exp_done, cur_tag, "R10 done timing", 32'(done_o), 32'(exp_done));
                end
                if (done_o) begin
                    chk(wb_base_o == exp_base, cur_tag, "R6 final base", wb_base_o, exp_base);
                    chk(wb_en_o == exp_wben, cur_tag, "R6 writeback strobe", 32'(wb_en_o), 32'(exp_wben));
                    chk(exp_idx_q.size() == 0, cur_tag, "R5 pairs left at done",
                        32'(exp_idx_q.size()), 32'd0);
                    seen_done = 1'b1;
                end
                if (hold_pend) begin
                    chk(req_valid_o && req_idx_o == hold_idx && req_addr_o == hold_addr,
                        cur_tag, "R11 stalled pair held", req_addr_o, hold_addr);
                end
                hold_pend = req_valid_o && !req_ready_i;
                hold_idx  = req_idx_o;
                hold_addr = req_addr_o;
                if (req_valid_o && req_ready_i) begin
                    if (exp_idx_q.size() == 0) begin
                        chk(1'b0, cur_tag, "R9 unexpected transfer", 32'(req_idx_o), 32'hFFFF_FFFF);
                    end else begin
                        int          ei;
                        logic [31:0] ea;
                        ei = exp_idx_q.pop_front();
                        ea = exp_addr_q.pop_front();
                        chk(32'(req_idx_o) == 32'(ei), cur_tag, "R5 index order", 32'(req_idx_o), 32'(ei));
                        chk(req_addr_o == ea, cur_tag, "address", req_addr_o, ea);
                        if (exp_idx_q.size() == 0) nxt_done = 1'b1;
                    end
                end
                if (start_i && !busy_o && reglist_i == '0) nxt_done = 1'b1;
                exp_done = nxt_done;
            end
        end
    end

    task automatic run_op(input string tag, input logic [31:0] b, input logic [15:0] l,
                          input bit st, input logic [1:0] kind, input bit ld,
                          input logic [1:0] md, input bit wb, input bit poke);
        logic [1:0]  em;
        int          n;
        logic [31:0] first;
        int          k;
        em = md;
        if (st) begin
            case ({ld, kind})
                3'b000: em = 2'd3;
                3'b001: em = 2'd1;
                3'b010: em = 2'd2;
                3'b011: em = 2'd0;
                3'b100: em = 2'd0;
                3'b101: em = 2'd2;
                3'b110: em = 2'd1;
                default: em = 2'd3;
            endcase
        end
        n = $countones(l);
        case (em)
            2'd0: begin first = b;             exp_base = b + 32'(4 * n); end
            2'd1: begin first = b + 4;         exp_base = b + 32'(4 * n); end
            2'd2: begin first = b - 32'(4 * n) + 4; exp_base = b - 32'(4 * n); end
            default: begin first = b - 32'(4 * n); exp_base = b - 32'(4 * n); end
        endcase
        exp_wben = wb;
        k = 0;
        for (int i = 0; i < 16; i++) begin
            if (l[i]) begin
                exp_idx_q.push_back(i);
                exp_addr_q.push_back(first + 32'(4 * k));
                k++;
            end
        end
        cur_tag   = tag;
        seen_done = 1'b0;
        @(posedge clk);
        #2;
        base_i = b; reglist_i = l; stack_sel_i = st; stack_kind_i = kind;
        load_i = ld; mode_i = md; wback_i = wb; start_i = 1'b1;
        @(posedge clk);
        #2;
        start_i = 1'b0;
        if (poke) begin
            // R12: a second start while busy must not disturb the sequence
            @(posedge clk);
            #2;
            chk(busy_o == 1'b1, tag, "R12 busy during sequence", 32'(busy_o), 32'd1);
            base_i = 32'hDEAD_0000; reglist_i = 16'hFFFF; mode_i = 2'd3;
            stack_sel_i = 1'b0; start_i = 1'b1;
            @(posedge clk);
            #2;
            start_i = 1'b0;
        end
        wait (seen_done);
        @(negedge clk);
        chk(busy_o == 1'b0 && req_valid_o == 1'b0, tag, "idle after done",
            32'({busy_o, req_valid_o}), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid_o == 1'b0, "R10", "reset valid", 32'(req_valid_o), 32'd0);
        chk(done_o == 1'b0, "R10", "reset done", 32'(done_o), 32'd0);
        chk(busy_o == 1'b0, "R12", "reset busy", 32'(busy_o), 32'd0);

        run_op("R1", 32'h0000_1000, 16'h80F1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0);
        run_op("R2", 32'h0000_2000, 16'h0006, 1'b0, 2'd0, 1'b1, 2'd1, 1'b1, 1'b0);
        run_op("R3", 32'h0000_3000, 16'h1111, 1'b0, 2'd0, 1'b0, 2'd2, 1'b1, 1'b0);
        run_op("R4", 32'h0000_4000, 16'h8001, 1'b0, 2'd0, 1'b1, 2'd3, 1'b1, 1'b0);
        run_op("R6", 32'h0000_5000, 16'h00F0, 1'b0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0);
        run_op("R12", 32'h0000_6000, 16'h0F0F, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1);

        for (int kd = 0; kd < 4; kd++) begin
            run_op("R7", 32'h0001_0000, 16'h4C21, 1'b1, 2'(kd), 1'b0, 2'(3 - kd), 1'b1, 1'b0);
            run_op("R8", 32'h0002_0000, 16'h4C21, 1'b1, 2'(kd), 1'b1, 2'(3 - kd), 1'b1, 1'b0);
        end

        for (int m = 0; m < 4; m++) begin
            run_op("R9", 32'h0003_0040, 16'h0000, 1'b0, 2'd0, 1'b0, 2'(m), 1'b1, 1'b0);
        end

        rnd_ready = 1'b1;
        run_op("R11", 32'h0000_8000, 16'hFFFF, 1'b0, 2'd0, 1'b1, 2'd3, 1'b1, 1'b0);
        run_op("R5", 32'h0000_9000, 16'hA5A5, 1'b0, 2'd0, 1'b0, 2'd2, 1'b1, 1'b0);
        run_op("R1", 32'hFFFF_FFF8, 16'h0007, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0);
        run_op("R4", 32'h0000_0004, 16'h0003, 1'b0, 2'd0, 1'b0, 2'd3, 1'b1, 1'b0);
        rnd_ready = 1'b0;

        repeat (4) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule